// File: doc/BRIEF.md
# Carry-Skip Adder

A purely combinational two-operand adder that splits its operands into equal groups of bits. Inside each group the carry ripples bit by bit. Beside that chain, a skip detector checks whether every bit of the group would pass an incoming carry straight through. When it would, a multiplexer routes the group's carry-in directly to its carry-out, so the carry does not wait for the ripple chain. Group carry-outs chain upward, and the last one becomes the adder's carry-out.

A build parameter selects how the ripple chain inside each group is built. In the plain variant every bit cell works in true polarity. In the alternating variant every odd-numbered bit of a group receives complemented operands and a complemented carry, and the sum bit is complemented back at the output. This is correct because a full adder is self-dual: complementing all three inputs complements both outputs. Both variants produce identical results. The block is used wherever a wide add must be faster than a plain ripple chain without the area of full lookahead.

Top module: `skip_carry_adder`

## Requirements
- R1: `{c_out, sum_out}` equals the unsigned sum `a_in + b_in + c_in` as a (WIDTH+1)-bit value for every input combination.
- R2: Operands are split into WIDTH/GRP groups of GRP bits, with group 0 holding bits GRP-1:0. Each group's carry-out is the next group's carry-in, `c_in` feeds group 0, and the top group's carry-out is `c_out`.
- R3: A group's skip term is 1 exactly when `a_in XOR b_in` is 1 on every bit of the group. This is the same as the group's two operand slices summing to all ones (for example 0101 with 1010). The pair 0101 with 1110 does not skip.
- R4: While a group's skip term is 1, its carry-out equals its carry-in.
- R5: While a group's skip term is 0, its carry-out does not depend on its carry-in. With group 0 holding 0101 and 1110, toggling `c_in` leaves `sum_out[15:4]` and `c_out` unchanged.
- R6: The build with alternating inverted-polarity bit stages (ALT_INV=1) gives the same `sum_out` and `c_out` as the plain build (ALT_INV=0) for every input.
- R7: When every group skips (`a_in`=16'h5555, `b_in`=16'hAAAA), `c_out` equals `c_in`. The sum is 16'hFFFF with `c_in`=0, and 16'h0000 with `c_out`=1 when `c_in`=1.
- R8: A carry born in bit 0 travels the whole width: 16'hFFFF + 16'h0001 with `c_in`=0 gives `sum_out`=16'h0000 and `c_out`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | WIDTH (16) | First operand |
| b_in | input | WIDTH (16) | Second operand |
| c_in | input | 1 | Carry into bit 0 |
| sum_out | output | WIDTH (16) | Sum bits |
| c_out | output | 1 | Carry out of the top bit |

## Verification
The bound checker evaluates four properties whenever the inputs change:
- the full arithmetic result;
- that a skipping group's operand slices sum to all ones;
- that a skipping group forwards its carry-in unchanged;
- that a non-skipping group's carry-out equals the carry its slices produce with either carry-in value.

Only the bench's scenarios can show the following:
- the directed skip patterns in each group;
- the toggle of the carry-in around a blocking group;
- the long ripple case;
- the agreement between the plain build and the alternating-polarity build on the same vectors.

// File: rtl/skip_adder_pkg.sv
package skip_adder_pkg;

    localparam int DEF_WIDTH = 16;
    localparam int DEF_GRP   = 4;

    // Per-group carry bookkeeping carried through the datapath
    typedef struct packed {
        logic skip;
        logic cin;
        logic cout;
    } grp_link_t;

    // True when bit stage idx works in complemented polarity
    function automatic bit stage_inv(input bit alt, input int idx);
        return alt && (idx % 2 == 1);
    endfunction

endpackage

// File: rtl/sca_bit_cell.sv
module sca_bit_cell (
    input  logic x,
    input  logic y,
    input  logic ci,
    output logic s,
    output logic co
);
    always_comb begin
        s  = x ^ y ^ ci;
        co = (x & y) | (ci & (x | y));
    end
endmodule

// File: rtl/sca_ripple_group.sv
module sca_ripple_group #(
    parameter int GRP     = 4,
    parameter bit ALT_INV = 1'b0
) (
    input  logic [GRP-1:0] a_g,
    input  logic [GRP-1:0] b_g,
    input  logic           cin,
    output logic [GRP-1:0] sum_g,
    output logic [GRP-1:0] prop_g,
    output logic           rip_cout
);
    import skip_adder_pkg::*;

    // link[i] carries the carry into bit i, stored in the polarity of bit i-1
    logic [GRP:0] link;
    assign link[0] = cin;

    for (genvar i = 0; i < GRP; i++) begin : g_bit
        localparam bit INV  = stage_inv(ALT_INV, i);
        localparam bit INVP = (i == 0) ? 1'b0 : stage_inv(ALT_INV, i - 1);
        logic xi, yi, ci, si, coi;

        if (INV) begin : g_neg
            assign xi = ~a_g[i];
            assign yi = ~b_g[i];
            assign sum_g[i] = ~si;
        end else begin : g_pos
            assign xi = a_g[i];
            assign yi = b_g[i];
            assign sum_g[i] = si;
        end

        if (INV != INVP) begin : g_flip
            assign ci = ~link[i];
        end else begin : g_keep
            assign ci = link[i];
        end

        assign prop_g[i] = a_g[i] ^ b_g[i];

        sca_bit_cell cell_i (
            .x (xi),
            .y (yi),
            .ci(ci),
            .s (si),
            .co(coi)
        );
        assign link[i+1] = coi;
    end

    if (stage_inv(ALT_INV, GRP - 1)) begin : g_out_neg
        assign rip_cout = ~link[GRP];
    end else begin : g_out_pos
        assign rip_cout = link[GRP];
    end
endmodule

// File: rtl/sca_skip_mux.sv
module sca_skip_mux #(
    parameter int GRP = 4
) (
    input  logic [GRP-1:0] prop_g,
    input  logic           cin,
    input  logic           rip_cout,
    output logic           skip,
    output logic           cout
);
    always_comb begin
        skip = &prop_g;
        cout = skip ? cin : rip_cout;
    end
endmodule

// File: rtl/skip_carry_adder.sv
module skip_carry_adder #(
    parameter int WIDTH   = skip_adder_pkg::DEF_WIDTH,
    parameter int GRP     = skip_adder_pkg::DEF_GRP,
    parameter bit ALT_INV = 1'b0
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             c_in,
    output logic [WIDTH-1:0] sum_out,
    output logic             c_out
);
    import skip_adder_pkg::*;

    localparam int NG = WIDTH / GRP;

    grp_link_t [NG-1:0] links;
    logic      [NG-1:0] grp_skip;
    logic      [NG-1:0] grp_cin;
    logic      [NG-1:0] grp_cout;

    for (genvar g = 0; g < NG; g++) begin : g_grp
        logic [GRP-1:0] prop_g;
        logic           rip_c;

        if (g == 0) begin : g_first
            assign links[g].cin = c_in;
        end else begin : g_next
            assign links[g].cin = links[g-1].cout;
        end

        sca_ripple_group #(.GRP(GRP), .ALT_INV(ALT_INV)) rip_i (
            .a_g     (a_in[g*GRP +: GRP]),
            .b_g     (b_in[g*GRP +: GRP]),
            .cin     (links[g].cin),
            .sum_g   (sum_out[g*GRP +: GRP]),
            .prop_g  (prop_g),
            .rip_cout(rip_c)
        );

        sca_skip_mux #(.GRP(GRP)) mux_i (
            .prop_g  (prop_g),
            .cin     (links[g].cin),
            .rip_cout(rip_c),
            .skip    (links[g].skip),
            .cout    (links[g].cout)
        );

        assign grp_skip[g] = links[g].skip;
        assign grp_cin[g]  = links[g].cin;
        assign grp_cout[g] = links[g].cout;
    end

    assign c_out = links[NG-1].cout;
endmodule

// File: rtl/skip_carry_adder_chk.sv
module skip_carry_adder_chk #(
    parameter int WIDTH = 16,
    parameter int GRP   = 4
) (
    input logic [WIDTH-1:0]      a_in,
    input logic [WIDTH-1:0]      b_in,
    input logic                  c_in,
    input logic [WIDTH-1:0]      sum_out,
    input logic                  c_out,
    input logic [WIDTH/GRP-1:0]  grp_skip,
    input logic [WIDTH/GRP-1:0]  grp_cin,
    input logic [WIDTH/GRP-1:0]  grp_cout
);
    localparam int NG = WIDTH / GRP;

    always_comb begin
        // R1
        sum_match_chk: assert ({c_out, sum_out} ==
            ({1'b0, a_in} + {1'b0, b_in} + {{WIDTH{1'b0}}, c_in}));
        for (int g = 0; g < NG; g++) begin
            automatic logic [GRP:0] t0 = {1'b0, a_in[g*GRP +: GRP]} + {1'b0, b_in[g*GRP +: GRP]};
            automatic logic [GRP:0] t1 = t0 + {{GRP{1'b0}}, 1'b1};
            if (grp_skip[g]) begin
                // R3
                skip_ones_chk: assert (t0 == {1'b0, {GRP{1'b1}}});
                // R4
                skip_pass_chk: assert (grp_cout[g] == grp_cin[g]);
            end else begin
                // R5
                noskip_indep_chk: assert (grp_cout[g] == t0[GRP] && t0[GRP] == t1[GRP]);
            end
        end
    end
endmodule

bind skip_carry_adder skip_carry_adder_chk #(.WIDTH(WIDTH), .GRP(GRP)) chk_i (
    .a_in    (a_in),
    .b_in    (b_in),
    .c_in    (c_in),
    .sum_out (sum_out),
    .c_out   (c_out),
    .grp_skip(grp_skip),
    .grp_cin (grp_cin),
    .grp_cout(grp_cout)
);

// File: tb/skip_carry_adder_tb_top.sv
module skip_carry_adder_tb_top;
    localparam int WIDTH = 16;
    localparam int GRP   = 4;
    localparam int NG    = WIDTH / GRP;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [WIDTH-1:0] a, b;
    logic             ci;
    logic [WIDTH-1:0] s_plain, s_alt;
    logic             co_plain, co_alt;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    skip_carry_adder #(.WIDTH(WIDTH), .GRP(GRP), .ALT_INV(1'b0)) dut_i (
        .a_in(a), .b_in(b), .c_in(ci), .sum_out(s_plain), .c_out(co_plain));

    skip_carry_adder #(.WIDTH(WIDTH), .GRP(GRP), .ALT_INV(1'b1)) dut_alt_i (
        .a_in(a), .b_in(b), .c_in(ci), .sum_out(s_alt), .c_out(co_alt));

    task automatic check(input string req, input logic [WIDTH:0] act, input logic [WIDTH:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (a=%h b=%h cin=%b)", req, act, exp, a, b, ci);
        end
    endtask

    // Drive away from the edge, sample one time unit later, check both builds
    task automatic apply(input logic [WIDTH-1:0] av, input logic [WIDTH-1:0] bv,
                         input logic cv, input string req);
        logic [WIDTH:0] exp;
        @(negedge clk);
        a = av; b = bv; ci = cv;
        #1;
        exp = {1'b0, av} + {1'b0, bv} + {{WIDTH{1'b0}}, cv};
        check({req, " R1 plain"}, {co_plain, s_plain}, exp);
        check({req, " R6 alt"}, {co_alt, s_alt}, exp);
    endtask

    task automatic t_reset_state();
        apply('0, '0, 1'b0, "reset");
    endtask

    task automatic t_group_skip();
        // R3 R4: one group at a time holds 0101/1010, the others carry a generate
        for (int g = 0; g < NG; g++) begin
            logic [WIDTH-1:0] av, bv;
            av = {WIDTH{1'b1}}; bv = 16'h1111;
            av[g*GRP +: GRP] = 4'b0101;
            bv[g*GRP +: GRP] = 4'b1010;
            apply(av, bv, 1'b0, "R3 R4 group skip");
            apply(av, bv, 1'b1, "R3 R4 group skip");
        end
    endtask

    task automatic t_all_skip();
        apply(16'h5555, 16'hAAAA, 1'b0, "R7 all skip");
        check("R7 sum cin0", {co_plain, s_plain}, {1'b0, 16'hFFFF});
        apply(16'h5555, 16'hAAAA, 1'b1, "R7 all skip");
        check("R7 sum cin1", {co_plain, s_plain}, {1'b1, 16'h0000});
        check("R7 alt cin1", {co_alt, s_alt}, {1'b1, 16'h0000});
    endtask

    task automatic t_blocking_group();
        logic [WIDTH:0] hi0, hi0a;
        apply(16'h1235, 16'h4CDE, 1'b0, "R5 block");
        hi0  = {co_plain, s_plain[15:4], 4'h0};
        hi0a = {co_alt, s_alt[15:4], 4'h0};
        apply(16'h1235, 16'h4CDE, 1'b1, "R5 block");
        check("R5 upper unchanged plain", {co_plain, s_plain[15:4], 4'h0}, hi0);
        check("R5 upper unchanged alt", {co_alt, s_alt[15:4], 4'h0}, hi0a);
    endtask

    task automatic t_long_ripple();
        apply(16'hFFFF, 16'h0001, 1'b0, "R8 ripple");
        check("R8 result", {co_plain, s_plain}, {1'b1, 16'h0000});
        apply(16'h7FFF, 16'h0000, 1'b1, "R8 ripple cin");
        apply(16'hFFFF, 16'hFFFF, 1'b1, "R8 max");
    endtask

    task automatic t_chain();
        // R2: carry born in group g must land in group g+1
        for (int g = 0; g < NG; g++) begin
            logic [WIDTH-1:0] av;
            av = '0;
            av[g*GRP +: GRP] = 4'hF;
            apply(av, 16'h0001 << (g*GRP), 1'b0, "R2 chain");
        end
    endtask

    task automatic t_random();
        for (int k = 0; k < 2000; k++) begin
            apply(WIDTH'($urandom), WIDTH'($urandom), 1'($urandom), "R1 R6 random");
        end
    endtask

    initial begin
        a = '0; b = '0; ci = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_reset_state();
        t_group_skip();
        t_all_skip();
        t_blocking_group();
        t_long_ripple();
        t_chain();
        t_random();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule